// File: doc/BRIEF.md
# Clustered Operand Bypass Network

This block forwards execution results straight to the operand inputs of the execution units, so a dependent operation does not have to wait for a register-file write and a later read. The units are split into two forwarding clusters: an integer domain and a floating-point/vector domain. Every unit presents a valid bit, a physical destination tag and a data word each cycle. That result is passed to the register-file write path and is also compared against every source tag of every unit.

A consumer in the same cluster as the producer picks up the result in the cycle it is broadcast, which is one cycle of producer-to-consumer latency. A consumer in the other cluster can only use a copy that has passed through a one-cycle staging register, which makes two cycles of latency. While the value is still in flight on a remote wire, the block lowers that source's ready flag so that the scheduler holds the consumer back. When no forwarding path matches, the register-file read value passes through. The number of units, the number of sources per unit, the widths and the cluster membership of each unit are all parameters.

Top module: `bypass_net`

## Requirements
- R1: When a valid result in the consumer's own cluster carries the source's tag in the current cycle, that source outputs the result data with ready high and path code 1, all in that same cycle.
- R2: If several same-cluster results match in one cycle, the unit with the lowest index supplies the data.
- R3: If the only current match is a result from the other cluster and no staged copy matches, the source drives ready low, path code 3, and the register-file data.
- R4: In the cycle after an other-cluster result is broadcast, a source whose tag matches it receives that result's data with ready high and path code 2. This applies only when no same-cluster result matches.
- R5: A current same-cluster match takes priority over a matching staged cross-cluster copy.
- R6: A source with no forwarding match passes its register-file data with ready high and path code 0. A staged copy is usable for exactly one cycle, so two cycles after the broadcast the source falls back to path code 0.
- R7: Asynchronous reset (rst_n low) clears every staging entry, so a result driven during reset is never forwarded after reset ends.
- R8: The register-file write outputs carry each unit's valid bit, tag and data unchanged, in the same cycle.
- R9: A result whose valid bit is low never matches, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | N | Per-unit result valid |
| res_tag | input | N*TAG_W | Per-unit destination tag; unit u uses bits [u*TAG_W +: TAG_W] |
| res_data | input | N*DATA_W | Per-unit result data; unit u uses bits [u*DATA_W +: DATA_W] |
| src_tag | input | N*SRCS*TAG_W | Source tags; source s belongs to unit s/SRCS |
| src_rf_data | input | N*SRCS*DATA_W | Register-file read value for each source |
| opnd_data | output | N*SRCS*DATA_W | Selected operand for each source |
| opnd_ready | output | N*SRCS | Operand available this cycle |
| opnd_path | output | N*SRCS*2 | Path code: 0 register file, 1 same cluster, 2 staged cross-cluster, 3 waiting |
| wb_valid | output | N | Register-file write valid |
| wb_tag | output | N*TAG_W | Register-file write tag |
| wb_data | output | N*DATA_W | Register-file write data |

## Verification
The main sweep takes each producer unit in turn and pairs it with each of the eight sources. It observes the three cycles that follow, and the ready flag's first rise separates one-cycle same-cluster latency from two-cycle cross-cluster latency. Directed patterns then drive two same-cluster results with the same tag to test the lowest-index rule. A staged copy competing with a fresh local match tests the priority order. A matching tag with its valid bit low shows that the valid bit gates matching. A result held during reset shows that the staging entries are cleared.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    PATH_RF     = 2'd0,
    PATH_LOCAL  = 2'd1,
    PATH_STAGED = 2'd2,
    PATH_WAIT   = 2'd3
  } path_e;

  // Two units share a forwarding cluster when their membership bits agree.
  function automatic logic in_cluster(logic prod_cl, logic cons_cl);
    return prod_cl == cons_cl;
  endfunction

  // Owning unit of a flattened source index.
  function automatic int unsigned unit_of_src(int unsigned src, int unsigned srcs);
    return src / srcs;
  endfunction

endpackage

// File: rtl/bypass_stage.sv
module bypass_stage #(
  parameter int N      = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        res_valid,
  input  logic [N*TAG_W-1:0]  res_tag,
  input  logic [N*DATA_W-1:0] res_data,
  output logic [N-1:0]        stg_valid,
  output logic [N*TAG_W-1:0]  stg_tag,
  output logic [N*DATA_W-1:0] stg_data
);

  for (genvar u = 0; u < N; u++) begin : g_unit
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else begin
        v_q <= res_valid[u];
        t_q <= res_tag[u*TAG_W +: TAG_W];
        d_q <= res_data[u*DATA_W +: DATA_W];
      end
    end

    assign stg_valid[u]                 = v_q;
    assign stg_tag[u*TAG_W +: TAG_W]    = t_q;
    assign stg_data[u*DATA_W +: DATA_W] = d_q;
  end

endmodule

// File: rtl/bypass_sel.sv
module bypass_sel
  import bypass_pkg::*;
#(
  parameter int         N      = 4,
  parameter int         TAG_W  = 6,
  parameter int         DATA_W = 32,
  parameter logic [N-1:0] CMAP = '0,
  parameter logic       MY_CL  = 1'b0
) (
  input  logic [N-1:0]        res_valid,
  input  logic [N*TAG_W-1:0]  res_tag,
  input  logic [N*DATA_W-1:0] res_data,
  input  logic [N-1:0]        stg_valid,
  input  logic [N*TAG_W-1:0]  stg_tag,
  input  logic [N*DATA_W-1:0] stg_data,
  input  logic [TAG_W-1:0]    src_tag,
  input  logic [DATA_W-1:0]   rf_data,
  output logic [DATA_W-1:0]   opnd_data,
  output logic                opnd_ready,
  output logic [1:0]          opnd_path,
  output logic [N-1:0]        local_hit,
  output logic [N-1:0]        stg_hit,
  output logic [N-1:0]        wait_hit
);

  logic [DATA_W-1:0] local_pick;
  logic [DATA_W-1:0] stg_pick;
  path_e             path;

  // Tag comparison against live and staged results, split by cluster.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      local_hit[i] = res_valid[i] && (res_tag[i*TAG_W +: TAG_W] == src_tag)
                     && in_cluster(CMAP[i], MY_CL);
      wait_hit[i]  = res_valid[i] && (res_tag[i*TAG_W +: TAG_W] == src_tag)
                     && !in_cluster(CMAP[i], MY_CL);
      stg_hit[i]   = stg_valid[i] && (stg_tag[i*TAG_W +: TAG_W] == src_tag)
                     && !in_cluster(CMAP[i], MY_CL);
    end
  end

  // Lowest index wins: scan downward so the last write is the lowest hit.
  always_comb begin
    local_pick = '0;
    stg_pick   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (local_hit[i]) local_pick = res_data[i*DATA_W +: DATA_W];
      if (stg_hit[i])   stg_pick   = stg_data[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (|local_hit)      path = PATH_LOCAL;
    else if (|stg_hit)   path = PATH_STAGED;
    else if (|wait_hit)  path = PATH_WAIT;
    else                 path = PATH_RF;
  end

  always_comb begin
    case (path)
      PATH_LOCAL:  opnd_data = local_pick;
      PATH_STAGED: opnd_data = stg_pick;
      default:     opnd_data = rf_data;
    endcase
  end

  assign opnd_ready = (path != PATH_WAIT);
  assign opnd_path  = path;

endmodule

// File: rtl/bypass_net.sv
module bypass_net
  import bypass_pkg::*;
#(
  parameter int           N           = 4,
  parameter int           SRCS        = 2,
  parameter int           TAG_W       = 6,
  parameter int           DATA_W      = 32,
  parameter logic [N-1:0] CLUSTER_MAP = 4'b1100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               res_valid,
  input  logic [N*TAG_W-1:0]         res_tag,
  input  logic [N*DATA_W-1:0]        res_data,
  input  logic [N*SRCS*TAG_W-1:0]    src_tag,
  input  logic [N*SRCS*DATA_W-1:0]   src_rf_data,
  output logic [N*SRCS*DATA_W-1:0]   opnd_data,
  output logic [N*SRCS-1:0]          opnd_ready,
  output logic [N*SRCS*2-1:0]        opnd_path,
  output logic [N-1:0]               wb_valid,
  output logic [N*TAG_W-1:0]         wb_tag,
  output logic [N*DATA_W-1:0]        wb_data
);

  localparam int NS = N * SRCS;

  logic [N-1:0]        stg_valid;
  logic [N*TAG_W-1:0]  stg_tag;
  logic [N*DATA_W-1:0] stg_data;

  // Per-source match events, brought out for observation.
  logic [NS*N-1:0] local_hit_all;
  logic [NS*N-1:0] stg_hit_all;
  logic [NS*N-1:0] wait_hit_all;

  assign wb_valid = res_valid;
  assign wb_tag   = res_tag;
  assign wb_data  = res_data;

  bypass_stage #(
    .N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_data  (res_data),
    .stg_valid (stg_valid),
    .stg_tag   (stg_tag),
    .stg_data  (stg_data)
  );

  for (genvar s = 0; s < NS; s++) begin : g_src
    localparam int U = unit_of_src(s, SRCS);

    bypass_sel #(
      .N(N), .TAG_W(TAG_W), .DATA_W(DATA_W),
      .CMAP(CLUSTER_MAP), .MY_CL(CLUSTER_MAP[U])
    ) u_sel (
      .res_valid  (res_valid),
      .res_tag    (res_tag),
      .res_data   (res_data),
      .stg_valid  (stg_valid),
      .stg_tag    (stg_tag),
      .stg_data   (stg_data),
      .src_tag    (src_tag[s*TAG_W +: TAG_W]),
      .rf_data    (src_rf_data[s*DATA_W +: DATA_W]),
      .opnd_data  (opnd_data[s*DATA_W +: DATA_W]),
      .opnd_ready (opnd_ready[s]),
      .opnd_path  (opnd_path[s*2 +: 2]),
      .local_hit  (local_hit_all[s*N +: N]),
      .stg_hit    (stg_hit_all[s*N +: N]),
      .wait_hit   (wait_hit_all[s*N +: N])
    );
  end

endmodule

// File: rtl/bypass_net_chk.sv
module bypass_net_chk
  import bypass_pkg::*;
#(
  parameter int           N      = 4,
  parameter int           SRCS   = 2,
  parameter int           TAG_W  = 6,
  parameter logic [N-1:0] CMAP   = 4'b1100
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N-1:0]            res_valid,
  input logic [N*TAG_W-1:0]      res_tag,
  input logic [N*SRCS*TAG_W-1:0] src_tag,
  input logic [N*SRCS-1:0]       opnd_ready,
  input logic [N*SRCS*2-1:0]     opnd_path,
  input logic [N-1:0]            stg_valid
);

  localparam int NS = N * SRCS;

  // R7: staging entries are empty on the first edge after reset ends.
  a_r7_stage_cleared: assert property (@(posedge clk)
    $rose(rst_n) |-> (stg_valid == '0));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    localparam logic MYC = CMAP[s / SRCS];
    logic local_now;

    always_comb begin
      local_now = 1'b0;
      for (int j = 0; j < N; j++)
        if (res_valid[j] && CMAP[j] == MYC &&
            res_tag[j*TAG_W +: TAG_W] == src_tag[s*TAG_W +: TAG_W])
          local_now = 1'b1;
    end

    a_r1_local_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      local_now |-> (opnd_ready[s] && opnd_path[s*2 +: 2] == PATH_LOCAL));

    a_r3_wait_holds_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_path[s*2 +: 2] == PATH_WAIT) |-> !opnd_ready[s]);

    a_r6_ready_unless_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      !opnd_ready[s] |-> (opnd_path[s*2 +: 2] == PATH_WAIT));

    for (genvar i = 0; i < N; i++) begin : g_rem
      if (CMAP[i] != MYC) begin : g_cross
        a_r4_staged_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(rst_n) && $past(res_valid[i]) &&
           $past(res_tag[i*TAG_W +: TAG_W]) == src_tag[s*TAG_W +: TAG_W] && !local_now)
          |-> (opnd_ready[s] && opnd_path[s*2 +: 2] == PATH_STAGED));
      end
    end
  end

endmodule

bind bypass_net bypass_net_chk #(
  .N(N), .SRCS(SRCS), .TAG_W(TAG_W), .CMAP(CLUSTER_MAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_tag    (res_tag),
  .src_tag    (src_tag),
  .opnd_ready (opnd_ready),
  .opnd_path  (opnd_path),
  .stg_valid  (stg_valid)
);

// File: tb/bypass_net_tb.sv
`timescale 1ns/1ps
module bypass_net_tb;

  localparam int N = 4, SRCS = 2, TAG_W = 6, DATA_W = 32, NS = N * SRCS;
  localparam logic [N-1:0] CMAP = 4'b1100;
  localparam logic [TAG_W-1:0] NOTAG = 6'd63;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [N-1:0]            res_valid;
  logic [N*TAG_W-1:0]      res_tag;
  logic [N*DATA_W-1:0]     res_data;
  logic [NS*TAG_W-1:0]     src_tag;
  logic [NS*DATA_W-1:0]    src_rf_data;
  logic [NS*DATA_W-1:0]    opnd_data;
  logic [NS-1:0]           opnd_ready;
  logic [NS*2-1:0]         opnd_path;
  logic [N-1:0]            wb_valid;
  logic [N*TAG_W-1:0]      wb_tag;
  logic [N*DATA_W-1:0]     wb_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bypass_net #(
    .N(N), .SRCS(SRCS), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLUSTER_MAP(CMAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_tag(res_tag),
    .res_data(res_data), .src_tag(src_tag), .src_rf_data(src_rf_data),
    .opnd_data(opnd_data), .opnd_ready(opnd_ready), .opnd_path(opnd_path),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  function automatic logic [DATA_W-1:0] rf_val(int s);
    return 32'hF000_0000 | s;
  endfunction

  function automatic logic [DATA_W-1:0] res_val(int p, int t);
    return 32'hA000_0000 | (p << 8) | t;
  endfunction

  task automatic clear_all();
    res_valid = '0;
    res_tag   = '0;
    res_data  = '0;
    for (int s = 0; s < NS; s++) src_tag[s*TAG_W +: TAG_W] = NOTAG;
  endtask

  task automatic drive(int p, int t, logic [DATA_W-1:0] d);
    res_valid[p] = 1'b1;
    res_tag[p*TAG_W +: TAG_W] = t[TAG_W-1:0];
    res_data[p*DATA_W +: DATA_W] = d;
  endtask

  task automatic check(string req, int s, logic [DATA_W-1:0] ed, logic er, logic [1:0] ep);
    logic [DATA_W-1:0] ad;
    logic [1:0] ap;
    ad = opnd_data[s*DATA_W +: DATA_W];
    ap = opnd_path[s*2 +: 2];
    checks++;
    if (ad !== ed || opnd_ready[s] !== er || ap !== ep) begin
      failures++;
      $display("FAIL %s src=%0d actual data=%h ready=%b path=%0d expected data=%h ready=%b path=%0d",
               req, s, ad, opnd_ready[s], ap, ed, er, ep);
    end
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) src_rf_data[s*DATA_W +: DATA_W] = rf_val(s);
    clear_all();
    // R7: a result present during reset must not be staged.
    drive(2, 5, 32'hDEAD_0005);
    src_tag[0*TAG_W +: TAG_W] = 6'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    res_valid = '0;
    #1 check("R7", 0, rf_val(0), 1'b1, 2'd0);

    // Sweep: every producer against every source, three cycles each.
    for (int p = 0; p < N; p++) begin
      for (int s = 0; s < NS; s++) begin
        int t;
        logic same;
        t = 10 + p;
        same = (CMAP[p] == CMAP[s / SRCS]);
        @(negedge clk); clear_all(); drive(p, t, res_val(p, t));
        src_tag[s*TAG_W +: TAG_W] = t[TAG_W-1:0];
        #1;
        if (same) check("R1", s, res_val(p, t), 1'b1, 2'd1);
        else      check("R3", s, rf_val(s), 1'b0, 2'd3);
        @(negedge clk); clear_all();
        src_tag[s*TAG_W +: TAG_W] = t[TAG_W-1:0];
        #1;
        if (same) check("R6", s, rf_val(s), 1'b1, 2'd0);
        else      check("R4", s, res_val(p, t), 1'b1, 2'd2);
        @(negedge clk); clear_all();
        src_tag[s*TAG_W +: TAG_W] = t[TAG_W-1:0];
        #1 check("R6", s, rf_val(s), 1'b1, 2'd0);
      end
    end

    // R2: two same-cluster producers with one tag; the lowest index wins.
    @(negedge clk); clear_all();
    drive(0, 20, 32'h1111_0000); drive(1, 20, 32'h2222_0000);
    drive(2, 21, 32'h3333_0000); drive(3, 21, 32'h4444_0000);
    src_tag[0*TAG_W +: TAG_W] = 6'd20;
    src_tag[6*TAG_W +: TAG_W] = 6'd21;
    src_tag[3*TAG_W +: TAG_W] = 6'd20;
    #1;
    check("R2", 0, 32'h1111_0000, 1'b1, 2'd1);
    check("R2", 6, 32'h3333_0000, 1'b1, 2'd1);
    check("R2", 3, 32'h1111_0000, 1'b1, 2'd1);
    // R8: write-back outputs mirror the results.
    checks++;
    if (wb_valid !== res_valid || wb_tag !== res_tag || wb_data !== res_data) begin
      failures++;
      $display("FAIL R8 actual valid=%b expected valid=%b", wb_valid, res_valid);
    end

    // R5: a staged copy and a fresh local result share a tag; the local one wins.
    @(negedge clk); clear_all();
    drive(2, 25, 32'h5555_0002);
    @(negedge clk); clear_all();
    drive(0, 25, 32'h6666_0000);
    src_tag[1*TAG_W +: TAG_W] = 6'd25;
    #1 check("R5", 1, 32'h6666_0000, 1'b1, 2'd1);

    // R9: an invalid result with a matching tag is ignored.
    @(negedge clk); clear_all();
    res_tag[0*TAG_W +: TAG_W] = 6'd30;
    res_tag[2*TAG_W +: TAG_W] = 6'd30;
    res_data = '1;
    src_tag[1*TAG_W +: TAG_W] = 6'd30;
    src_tag[5*TAG_W +: TAG_W] = 6'd30;
    #1;
    check("R9", 1, rf_val(1), 1'b1, 2'd0);
    check("R9", 5, rf_val(5), 1'b1, 2'd0);
    @(negedge clk); clear_all();
    src_tag[5*TAG_W +: TAG_W] = 6'd30;
    #1 check("R9", 5, rf_val(5), 1'b1, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule